// File: doc/BRIEF.md
# SPI Queue FIFO and Status Flag Unit

This block sits between the host side of an SPI controller and its serial shifter. It buffers words waiting to be shifted out in a transmit FIFO and frames already shifted in in a receive FIFO. It also derives the level conditions, DMA requests, sticky event flags and the single interrupt line. Software or a DMA engine uses these to move queues held in system memory into and out of the controller. The serial shifter itself and the register bus decode are outside this block.

All data paths are valid/ready. On the host transmit port a word is taken in any cycle where `htx_valid` and `htx_ready` are both high. `htx_ready` falls when the transmit FIFO is full, except in bypass mode, where it stays high. On the host receive port and on the shifter transmit port, the block presents `*_valid` whenever it holds data, and a word leaves on `valid && ready`. The shifter receive port cannot be held off, because a frame arrives at a time set by the serial clock. `srx_ready` only reports room, and a frame offered while it is low is dropped and flagged. A per-word "last in queue" mark travels with each transmit word. `frame_done` is a one-cycle strobe from the shifter at the end of every serial frame.

In bypass mode each FIFO shrinks to a single holding stage. A fresh transmit word replaces one the shifter has not yet taken, so the newest value reaches the shifter with the least delay. Change `cfg_bypass` only while both FIFOs are empty.

Top module: `spi_qfifo_flags`

## Requirements
- R1: After reset both FIFOs are empty, all counts and pointers are 0, every sticky flag is 0, `htx_ready` is 1, and `hrx_valid`, `stx_valid` and `irq` are 0.
- R2: Each FIFO holds DEPTH (16) words and delivers them in arrival order. `htx_ready` is 0 when the transmit FIFO holds 16 words outside bypass mode, and a push offered then changes neither the count nor the data order.
- R3: `tx_not_full` is 1 whenever the transmit count is below capacity, and `rx_not_empty` is 1 whenever the receive count is nonzero. With `dma_tx_sel`=1 the first drives `dma_tx_req` and is removed from the interrupt; `dma_rx_sel` does the same for the second and `dma_rx_req`.
- R4: The transmit underflow flag (`stat_flags[2]`) is set only when `cfg_slave`=1 and `stx_ready`=1 while `stx_valid`=0. `stx_data` is all zeros while the transmit FIFO is empty.
- R5: A frame offered on the shifter receive port while the receive FIFO is full is discarded, the stored words are unchanged, and the receive overflow flag (`stat_flags[3]`) is set.
- R6: `overrun` is the OR of the transmit underflow and receive overflow flags.
- R7: The transfer-complete flag (`stat_flags[0]`) is set by every `frame_done`. The end-of-queue flag (`stat_flags[1]`) is set by a `frame_done` that ends a frame whose word carried the last mark when the shifter took it.
- R8: Sticky flags are cleared by a cycle with `clr_valid`=1 for each bit set in `clr_mask`, and other bits are unchanged. A set event in the same cycle wins over a clear.
- R9: `irq` is the OR over `irq_en` bits 0..3 (sticky flags in `stat_flags` order), bit 4 (`tx_not_full`, unless `dma_tx_sel`) and bit 5 (`rx_not_empty`, unless `dma_rx_sel`).
- R10: With `cfg_bypass`=1 each FIFO holds one word. A transmit push into a full stage replaces the held word, and a receive frame into a full stage is dropped as in R5.
- R11: The debug ports give each FIFO's fill count and its read and write pointers. The pointers advance by one per pop or push and wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slave | input | 1 | 1 = controller runs as slave |
| cfg_bypass | input | 1 | 1 = single-stage bypass mode |
| htx_valid | input | 1 | Host offers a transmit word |
| htx_ready | output | 1 | Transmit side can accept |
| htx_data | input | DW | Transmit word |
| htx_last | input | 1 | Word is last of its queue |
| hrx_valid | output | 1 | Received word available |
| hrx_ready | input | 1 | Host takes received word |
| hrx_data | output | DW | Oldest received word |
| stx_valid | output | 1 | Transmit word available to shifter |
| stx_ready | input | 1 | Shifter takes a word (frame start) |
| stx_data | output | DW | Word for shifter, zero when empty |
| stx_last | output | 1 | Last mark of presented word |
| srx_valid | input | 1 | Shifter delivers a received frame |
| srx_ready | output | 1 | Receive FIFO has room |
| srx_data | input | DW | Received frame |
| frame_done | input | 1 | End of a serial frame strobe |
| clr_valid | input | 1 | Flag clear write |
| clr_mask | input | 4 | Write-one-to-clear mask |
| irq_en | input | 6 | Interrupt source enables |
| dma_tx_sel | input | 1 | Route transmit room to DMA |
| dma_rx_sel | input | 1 | Route receive data to DMA |
| stat_flags | output | 4 | Sticky flags: 0 done, 1 end of queue, 2 underflow, 3 overflow |
| tx_not_full | output | 1 | Transmit FIFO has room |
| rx_not_empty | output | 1 | Receive FIFO holds data |
| overrun | output | 1 | Underflow or overflow flag set |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | DMA request, transmit |
| dma_rx_req | output | 1 | DMA request, receive |
| tx_count | output | CW | Transmit fill count |
| tx_rptr | output | PW | Transmit read pointer |
| tx_wptr | output | PW | Transmit write pointer |
| rx_count | output | CW | Receive fill count |
| rx_rptr | output | PW | Receive read pointer |
| rx_wptr | output | PW | Receive write pointer |

## Verification
A push, pop, dropped frame or flag event changes state at the clock edge that samples it. Counts, pointers, `*_valid`, `*_ready`, the data outputs and the sticky flags are therefore correct one cycle after the stimulus, and `irq`, `overrun` and the DMA requests follow in the same cycle through gates alone. The bench drives inputs just after a rising edge, lets exactly one edge pass, and reads the outputs just after that edge, before anything else changes. Combinational paths such as `stx_data` going to zero on an empty FIFO or `irq` following `irq_en` are checked after a short settle with no edge in between.

// File: rtl/spi_qf_pkg.sv
package spi_qf_pkg;
  localparam int NFLAG   = 4;
  localparam int FL_TCF  = 0;
  localparam int FL_EOQ  = 1;
  localparam int FL_TXUF = 2;
  localparam int FL_RXOF = 3;
  localparam int SRC_TXNF = 4;
  localparam int SRC_RXNE = 5;
  localparam int NSRC     = 6;
endpackage

// File: rtl/spi_qf_fifo.sv
module spi_qf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic          ovw_en,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] wptr
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cap;
  logic          do_push, do_ovw, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign cap     = bypass ? CW'(1) : CW'(DEPTH);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || (ovw_en && do_pop));
  assign do_ovw  = push && full && ovw_en && !do_pop;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    else if (do_ovw) mem[rptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      rptr  <= '0;
      wptr  <= '0;
    end else begin
      count <= count + CW'(do_push) - CW'(do_pop);
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R11
  ptr_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(wptr) - int'(rptr) + DEPTH) % DEPTH) == (int'(count) % DEPTH));
endmodule

// File: rtl/spi_qf_flags.sv
module spi_qf_flags
  import spi_qf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             clr_valid,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             tx_nf,
  input  logic             rx_ne,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             dma_tx_sel,
  input  logic             dma_rx_sel,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             overrun,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  logic [NSRC-1:0] src;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                        flags[i] <= 1'b0;
      else if (evt[i])                   flags[i] <= 1'b1;
      else if (clr_valid && clr_mask[i]) flags[i] <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && clr_mask[i] && !evt[i]) |=> !flags[i]);
  end

  assign src[NFLAG-1:0] = flags;
  assign src[SRC_TXNF]  = tx_nf && !dma_tx_sel;
  assign src[SRC_RXNE]  = rx_ne && !dma_rx_sel;
  assign irq        = |(src & irq_en);
  assign overrun    = flags[FL_TXUF] | flags[FL_RXOF];
  assign dma_tx_req = tx_nf && dma_tx_sel;
  assign dma_rx_req = rx_ne && dma_rx_sel;
endmodule

// File: rtl/spi_qfifo_flags.sv
module spi_qfifo_flags
  import spi_qf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slave,
  input  logic             cfg_bypass,
  input  logic             htx_valid,
  output logic             htx_ready,
  input  logic [DW-1:0]    htx_data,
  input  logic             htx_last,
  output logic             hrx_valid,
  input  logic             hrx_ready,
  output logic [DW-1:0]    hrx_data,
  output logic             stx_valid,
  input  logic             stx_ready,
  output logic [DW-1:0]    stx_data,
  output logic             stx_last,
  input  logic             srx_valid,
  output logic             srx_ready,
  input  logic [DW-1:0]    srx_data,
  input  logic             frame_done,
  input  logic             clr_valid,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic [NSRC-1:0]  irq_en,
  input  logic             dma_tx_sel,
  input  logic             dma_rx_sel,
  output logic [NFLAG-1:0] stat_flags,
  output logic             tx_not_full,
  output logic             rx_not_empty,
  output logic             overrun,
  output logic             irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req,
  output logic [CW-1:0]    tx_count,
  output logic [PW-1:0]    tx_rptr,
  output logic [PW-1:0]    tx_wptr,
  output logic [CW-1:0]    rx_count,
  output logic [PW-1:0]    rx_rptr,
  output logic [PW-1:0]    rx_wptr
);
  logic [DW:0]      tx_rd;
  logic             tx_full, tx_empty, tx_pop;
  logic             rx_full, rx_empty, rx_pop;
  logic             cur_last;
  logic [NFLAG-1:0] evt;

  spi_qf_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .bypass(cfg_bypass), .ovw_en(cfg_bypass),
    .push(htx_valid), .wdata({htx_last, htx_data}), .pop(tx_pop),
    .rdata(tx_rd), .full(tx_full), .empty(tx_empty),
    .count(tx_count), .rptr(tx_rptr), .wptr(tx_wptr));

  spi_qf_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .bypass(cfg_bypass), .ovw_en(1'b0),
    .push(srx_valid), .wdata(srx_data), .pop(rx_pop),
    .rdata(hrx_data), .full(rx_full), .empty(rx_empty),
    .count(rx_count), .rptr(rx_rptr), .wptr(rx_wptr));

  assign htx_ready    = !tx_full || cfg_bypass;
  assign stx_valid    = !tx_empty;
  assign stx_data     = stx_valid ? tx_rd[DW-1:0] : '0;
  assign stx_last     = stx_valid && tx_rd[DW];
  assign tx_pop       = stx_valid && stx_ready;
  assign hrx_valid    = !rx_empty;
  assign rx_pop       = hrx_valid && hrx_ready;
  assign srx_ready    = !rx_full;
  assign tx_not_full  = !tx_full;
  assign rx_not_empty = !rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)          cur_last <= 1'b0;
    else if (tx_pop)     cur_last <= tx_rd[DW];
    else if (frame_done) cur_last <= 1'b0;
  end

  assign evt[FL_TCF]  = frame_done;
  assign evt[FL_EOQ]  = frame_done && cur_last;
  assign evt[FL_TXUF] = cfg_slave && stx_ready && tx_empty;
  assign evt[FL_RXOF] = srx_valid && rx_full;

  spi_qf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .tx_nf(tx_not_full), .rx_ne(rx_not_empty),
    .irq_en(irq_en), .dma_tx_sel(dma_tx_sel), .dma_rx_sel(dma_rx_sel),
    .flags(stat_flags), .irq(irq), .overrun(overrun),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  // R4
  under_slave_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[FL_TXUF]) |-> $past(cfg_slave));

  // R5
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srx_valid && !srx_ready && !rx_pop) |=> (rx_count == $past(rx_count)));

  // R7
  eoq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flags[FL_EOQ]) |-> $past(frame_done));

  // R4
  under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stx_valid |-> (stx_data == '0));
endmodule

// File: tb/sim_spi_qfifo_flags.sv
module sim_spi_qfifo_flags;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_slave = 0, cfg_bypass = 0;
  logic htx_valid = 0, htx_last = 0, hrx_ready = 0, stx_ready = 0;
  logic srx_valid = 0, frame_done = 0, clr_valid = 0;
  logic dma_tx_sel = 0, dma_rx_sel = 0;
  logic [DW-1:0] htx_data = '0, srx_data = '0;
  logic [3:0] clr_mask = '0;
  logic [5:0] irq_en = '0;
  logic htx_ready, hrx_valid, stx_valid, stx_last, srx_ready;
  logic [DW-1:0] hrx_data, stx_data;
  logic [3:0] stat_flags;
  logic tx_not_full, rx_not_empty, overrun, irq, dma_tx_req, dma_rx_req;
  logic [CW-1:0] tx_count, rx_count;
  logic [PW-1:0] tx_rptr, tx_wptr, rx_rptr, rx_wptr;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_qfifo_flags #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(input logic [DW-1:0] d, input logic l);
    htx_valid = 1; htx_data = d; htx_last = l; step(); htx_valid = 0; htx_last = 0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d);
    srx_valid = 1; srx_data = d; step(); srx_valid = 0;
  endtask

  task automatic clear_all();
    clr_valid = 1; clr_mask = 4'hF; step(); clr_valid = 0; clr_mask = 0;
  endtask

  task automatic t_reset();
    check("R1", "tx_count", 32'(tx_count), 0);
    check("R1", "rx_count", 32'(rx_count), 0);
    check("R1", "flags", 32'(stat_flags), 0);
    check("R1", "htx_ready", 32'(htx_ready), 1);
    check("R1", "valids_irq", {29'b0, hrx_valid, stx_valid, irq}, 0);
    check("R1", "ptrs", {16'b0, tx_rptr, tx_wptr, rx_rptr, rx_wptr}, 0);
  endtask

  task automatic t_tx_queue();
    int bad = 0;
    dma_tx_sel = 1; #1;
    check("R3", "dma_tx_req empty", 32'(dma_tx_req), 1);
    for (int i = 0; i < 16; i++) push_tx(DW'(16'h100 + i), i == 15);
    check("R2", "htx_ready full", 32'(htx_ready), 0);
    check("R2", "tx_count full", 32'(tx_count), 16);
    check("R3", "tx_not_full/dma full", {tx_not_full, dma_tx_req}, 0);
    check("R11", "tx ptrs after 16", {tx_rptr, tx_wptr}, 0);
    push_tx(16'hDEAD, 1'b0);
    check("R2", "count after refused push", 32'(tx_count), 16);
    for (int i = 0; i < 16; i++) begin
      if (stx_data !== DW'(16'h100 + i) || stx_last !== (i == 15)) bad++;
      stx_ready = 1; step(); stx_ready = 0;
      frame_done = 1; step(); frame_done = 0;
      if (i == 0) begin
        check("R7", "tcf after frame", 32'(stat_flags[0]), 1);
        check("R7", "eoq not on plain frame", 32'(stat_flags[1]), 0);
        check("R11", "tx_rptr after one pop", 32'(tx_rptr), 1);
      end
    end
    check("R2", "tx order mismatches", bad, 0);
    check("R7", "eoq after last frame", 32'(stat_flags[1]), 1);
    dma_tx_sel = 0;
  endtask

  task automatic t_w1c();
    clr_valid = 1; clr_mask = 4'b0001; step(); clr_valid = 0;
    check("R8", "tcf cleared eoq kept", 32'(stat_flags[1:0]), 2'b10);
    clr_valid = 1; clr_mask = 4'b0000; step(); clr_valid = 0;
    check("R8", "zero mask keeps", 32'(stat_flags[1:0]), 2'b10);
    clr_valid = 1; clr_mask = 4'b0001; frame_done = 1; step();
    clr_valid = 0; frame_done = 0; clr_mask = 0;
    check("R8", "set wins over clear", 32'(stat_flags[0]), 1);
    clear_all();
    check("R8", "all cleared", 32'(stat_flags), 0);
  endtask

  task automatic t_underflow();
    stx_ready = 1; step(); stx_ready = 0;
    check("R4", "no underflow in master", 32'(stat_flags[2]), 0);
    cfg_slave = 1; stx_ready = 1; #1;
    check("R4", "zeros when empty", 32'(stx_data), 0);
    step(); stx_ready = 0;
    check("R4", "underflow in slave", 32'(stat_flags[2]), 1);
    check("R6", "overrun from underflow", 32'(overrun), 1);
    cfg_slave = 0;
    clear_all();
    check("R6", "overrun cleared", 32'(overrun), 0);
  endtask

  task automatic t_rx_queue();
    int bad = 0;
    dma_rx_sel = 1;
    for (int i = 0; i < 16; i++) push_rx(DW'(16'h200 + i));
    check("R5", "srx_ready full", 32'(srx_ready), 0);
    check("R3", "rx_ne/dma_rx_req", {rx_not_empty, dma_rx_req}, 2'b11);
    check("R5", "no overflow yet", 32'(stat_flags[3]), 0);
    push_rx(16'hBEEF);
    check("R5", "overflow flag", 32'(stat_flags[3]), 1);
    check("R6", "overrun from overflow", 32'(overrun), 1);
    check("R5", "rx_count kept", 32'(rx_count), 16);
    for (int i = 0; i < 16; i++) begin
      if (hrx_data !== DW'(16'h200 + i)) bad++;
      hrx_ready = 1; step(); hrx_ready = 0;
    end
    check("R5", "rx order, dropped frame absent", bad, 0);
    check("R3", "rx empty after drain", {hrx_valid, rx_not_empty, dma_rx_req}, 0);
    check("R11", "rx ptrs wrapped", {rx_rptr, rx_wptr}, 0);
    dma_rx_sel = 0;
    clear_all();
  endtask

  task automatic t_irq();
    irq_en = 6'b010000; #1;
    check("R9", "irq from tx room", 32'(irq), 1);
    dma_tx_sel = 1; #1;
    check("R3", "dma takes tx room", {irq, dma_tx_req}, 2'b01);
    irq_en = 6'b000010; frame_done = 1; step(); frame_done = 0;
    check("R9", "irq off, only tcf set", 32'(irq), 0);
    irq_en = 6'b000011; #1;
    check("R9", "irq on tcf enabled", 32'(irq), 1);
    irq_en = 0; dma_tx_sel = 0;
    clear_all();
  endtask

  task automatic t_bypass();
    cfg_bypass = 1;
    push_tx(16'h00A1, 1'b0);
    check("R10", "bypass tx one word, ready", {27'b0, tx_count, htx_ready}, {27'b0, 5'd1, 1'b1});
    push_tx(16'h00A2, 1'b0);
    check("R10", "bypass overwrite", {tx_count, stx_data}, {5'd1, 16'h00A2});
    stx_ready = 1; step(); stx_ready = 0;
    push_rx(16'h00C1);
    check("R10", "bypass rx full", 32'(srx_ready), 0);
    push_rx(16'h00C2);
    check("R10", "bypass rx drop", {stat_flags[3], rx_count, hrx_data}, {1'b1, 5'd1, 16'h00C1});
    hrx_ready = 1; step(); hrx_ready = 0;
    cfg_bypass = 0;
    clear_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_tx_queue();
    t_w1c();
    t_underflow();
    t_rx_queue();
    t_irq();
    t_bypass();
    finish_run();
  end
endmodule